// File: doc/BRIEF.md
# Three-Level PWM Phase Sequencer

This block drives one power phase's PWM pin in the three-level code that driver stages accept: drive high, drive low, or release the pin to high impedance. Each switching period opens with a one-clock period tick. The block compares an externally generated digital ramp against a digital control level (the compensation code) to decide where the on-pulse ends. An internal position counter, restarted by every tick, enforces the maximum on-position (minimum off-time). It also places the short forced-low refresh pulse of the start-up phase.

Switching starts from a released pin. The first `NSYNC_CYCLES` periods run nonsynchronously: each on-pulse falls back to high impedance, and the last `LOW_PULSE_TICKS` clocks of the period force the pin low so that the driver's bootstrap supply can recharge. After that the phase switches in forced-continuous fashion, high then low. An overcurrent fault or a dropped enable releases the pin and returns the block to idle, so every restart repeats the nonsynchronous sequence. An overvoltage flag overrides switching and forces the pin low.

Top module: `pwm_tristate_seq`

## Requirements
- R1: After reset, while `en` is low, and in idle before start-up, `pwm_state` is high impedance (2'b10).
- R2: Start-up is taken only on a clock edge where `cyc_tick` is high, `en` is high, `oc_fault` and `prebias` are low, and either `comp` > `COMP_MIN` or `ss_level` > `SS_MIN`. The period that begins at that tick is the first switching period.
- R3: Positions count clock edges from the period tick (position 0 is the output registered on the tick's edge). In each of the first `NSYNC_CYCLES` periods after start-up, a pulsed period reads high from position 0, then high impedance, then low for positions `PERIOD_TICKS-LOW_PULSE_TICKS` to `PERIOD_TICKS-1`.
- R4: From period `NSYNC_CYCLES+1` onward the output is high from position 0 and low afterwards. The first position that is not high is the first position n ≥ 1 whose `ramp` input, sampled on that same edge, exceeds `comp`, subject to R6 and R7.
- R5: A period drives high at position 0 only if `comp` > `COMP_MIN` on the tick's edge. Otherwise the whole period is low in forced-continuous operation, or high impedance in nonsynchronous operation.
- R6: A high pulse lasts at least `MIN_ON_TICKS` positions unless R7, R8 or R9 cut it.
- R7: The output is never high at a position at or beyond `PERIOD_TICKS - PERIOD_TICKS/12`.
- R8: While running, `ov_flag` forces the output low on the next edge. It stays low until a period tick sees `ov_flag` clear.
- R9: `oc_fault` releases the output to high impedance on the next edge and returns the block to idle. The next start-up reruns all `NSYNC_CYCLES` nonsynchronous periods.
- R10: Codes are 2'b00 low, 2'b01 high, 2'b10 high impedance; 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One-clock pulse opening each switching period |
| ramp | input | VAL_W | Ramp code, compared against `comp` |
| comp | input | VAL_W | Control level code |
| ss_level | input | VAL_W | Soft-start level code |
| en | input | 1 | Phase enable |
| prebias | input | 1 | Output already charged; blocks start-up |
| oc_fault | input | 1 | Overcurrent shutdown request |
| ov_flag | input | 1 | Overvoltage; forces low |
| pwm_state | output | 2 | Three-level PWM code |

## Verification
Every result is registered once, so the pin code for position n appears on the edge that samples the tick (n = 0) or the n-th ramp value. Overvoltage and fault reactions show one edge after the flag is sampled. The bench drives inputs on the falling edge, samples one nanosecond after each rising edge, and compares a whole period of 48 samples position by position with a pattern computed from the requirement formulas. Mode changes are checked through the shape of whole periods: the seventh and eighth periods after a start must differ in their tail.

// File: rtl/pwm_seq_pkg.sv
`timescale 1ns/1ps
package pwm_seq_pkg;

    typedef enum logic [1:0] {
        PWM_LO = 2'b00,
        PWM_HI = 2'b01,
        PWM_HZ = 2'b10
    } pwm_code_e;

    typedef enum logic [1:0] {
        MD_IDLE  = 2'b00,
        MD_NSYNC = 2'b01,
        MD_FCCM  = 2'b10
    } seq_mode_e;

endpackage

// File: rtl/pwm_seq_gate.sv
`timescale 1ns/1ps
module pwm_seq_gate #(
    parameter int VAL_W    = 8,
    parameter int COMP_MIN = 10,
    parameter int SS_MIN   = 18
) (
    input  logic             en,
    input  logic             oc_fault,
    input  logic             prebias,
    input  logic [VAL_W-1:0] comp,
    input  logic [VAL_W-1:0] ss_level,
    output logic             comp_above,
    output logic             start_ok
);
    localparam logic [VAL_W-1:0] COMP_MIN_V = VAL_W'(COMP_MIN);
    localparam logic [VAL_W-1:0] SS_MIN_V   = VAL_W'(SS_MIN);

    logic ss_above;

    assign comp_above = comp > COMP_MIN_V;
    assign ss_above   = ss_level > SS_MIN_V;
    assign start_ok   = en && !oc_fault && !prebias && (comp_above || ss_above);

endmodule

// File: rtl/pwm_seq_pos.sv
`timescale 1ns/1ps
module pwm_seq_pos #(
    parameter int PERIOD_TICKS = 48,
    parameter int POS_W        = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [POS_W-1:0] pos_nxt,
    output logic [POS_W-1:0] pos_q
);
    localparam logic [POS_W-1:0] LAST_V = POS_W'(PERIOD_TICKS - 1);

    logic [POS_W-1:0] pos_d;

    always_comb begin
        if (tick)                pos_d = '0;
        else if (pos_q == LAST_V) pos_d = pos_q;
        else                     pos_d = pos_q + POS_W'(1);
    end

    assign pos_nxt = pos_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos_q <= LAST_V;
        else        pos_q <= pos_d;
    end

endmodule

// File: rtl/pwm_tristate_seq.sv
`timescale 1ns/1ps
module pwm_tristate_seq #(
    parameter int VAL_W           = 8,
    parameter int PERIOD_TICKS    = 48,
    parameter int MIN_ON_TICKS    = 4,
    parameter int LOW_PULSE_TICKS = 4,
    parameter int NSYNC_CYCLES    = 7,
    parameter int COMP_MIN        = 10,
    parameter int SS_MIN          = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_tick,
    input  logic [VAL_W-1:0] ramp,
    input  logic [VAL_W-1:0] comp,
    input  logic [VAL_W-1:0] ss_level,
    input  logic             en,
    input  logic             prebias,
    input  logic             oc_fault,
    input  logic             ov_flag,
    output logic [1:0]       pwm_state
);
    import pwm_seq_pkg::*;

    localparam int MIN_OFF_TICKS = PERIOD_TICKS / 12;
    localparam int HI_LIMIT      = PERIOD_TICKS - MIN_OFF_TICKS;
    localparam int LOW_START     = PERIOD_TICKS - LOW_PULSE_TICKS;
    localparam int POS_W         = $clog2(PERIOD_TICKS);
    localparam int ON_W          = $clog2(MIN_ON_TICKS + 1);
    localparam int NS_W          = $clog2(NSYNC_CYCLES + 1);

    localparam logic [POS_W-1:0] HI_LIM_V  = POS_W'(HI_LIMIT);
    localparam logic [POS_W-1:0] LOW_ST_V  = POS_W'(LOW_START);
    localparam logic [ON_W-1:0]  MIN_ON_V  = ON_W'(MIN_ON_TICKS);
    localparam logic [NS_W-1:0]  NS_LAST_V = NS_W'(NSYNC_CYCLES - 1);

    typedef struct packed {
        seq_mode_e        mode;
        logic             hi;
        logic [ON_W-1:0]  on_cnt;
        logic [NS_W-1:0]  ns_cnt;
        logic             pulsed;
        logic             held_low;
        pwm_code_e        pwm;
    } seq_st_t;

    seq_st_t          st_q, st_d;
    logic [POS_W-1:0] pos_nxt, pos_q;
    logic             comp_above, start_ok, run_ok;

    pwm_seq_gate #(
        .VAL_W    (VAL_W),
        .COMP_MIN (COMP_MIN),
        .SS_MIN   (SS_MIN)
    ) u_gate (
        .en         (en),
        .oc_fault   (oc_fault),
        .prebias    (prebias),
        .comp       (comp),
        .ss_level   (ss_level),
        .comp_above (comp_above),
        .start_ok   (start_ok)
    );

    pwm_seq_pos #(
        .PERIOD_TICKS (PERIOD_TICKS),
        .POS_W        (POS_W)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (cyc_tick),
        .pos_nxt (pos_nxt),
        .pos_q   (pos_q)
    );

    assign run_ok = en && !oc_fault;

    always_comb begin
        st_d = st_q;
        if (!run_ok) begin
            st_d.mode     = MD_IDLE;
            st_d.hi       = 1'b0;
            st_d.on_cnt   = '0;
            st_d.ns_cnt   = '0;
            st_d.pulsed   = 1'b0;
            st_d.held_low = 1'b0;
        end else begin
            if (cyc_tick) begin
                case (st_q.mode)
                    MD_IDLE: begin
                        if (start_ok) begin
                            st_d.mode   = MD_NSYNC;
                            st_d.ns_cnt = '0;
                        end
                    end
                    MD_NSYNC: begin
                        if (st_q.ns_cnt == NS_LAST_V) st_d.mode = MD_FCCM;
                        else                          st_d.ns_cnt = st_q.ns_cnt + NS_W'(1);
                    end
                    default: ;
                endcase
                st_d.held_low = 1'b0;
                st_d.pulsed   = 1'b0;
                st_d.hi       = 1'b0;
                st_d.on_cnt   = '0;
                if (st_d.mode != MD_IDLE && comp_above) begin
                    st_d.hi     = 1'b1;
                    st_d.on_cnt = ON_W'(1);
                    st_d.pulsed = 1'b1;
                end
            end else if (st_q.hi) begin
                if (((ramp > comp) && (st_q.on_cnt >= MIN_ON_V)) || (pos_nxt >= HI_LIM_V)) begin
                    st_d.hi = 1'b0;
                end else if (st_q.on_cnt != MIN_ON_V) begin
                    st_d.on_cnt = st_q.on_cnt + ON_W'(1);
                end
            end
            if (ov_flag && st_d.mode != MD_IDLE) begin
                st_d.hi       = 1'b0;
                st_d.held_low = 1'b1;
            end
        end

        if (st_d.mode == MD_IDLE)                          st_d.pwm = PWM_HZ;
        else if (st_d.hi)                                  st_d.pwm = PWM_HI;
        else if (st_d.mode == MD_FCCM || st_d.held_low)    st_d.pwm = PWM_LO;
        else if (st_d.pulsed && pos_nxt >= LOW_ST_V)       st_d.pwm = PWM_LO;
        else                                               st_d.pwm = PWM_HZ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode     <= MD_IDLE;
            st_q.hi       <= 1'b0;
            st_q.on_cnt   <= '0;
            st_q.ns_cnt   <= '0;
            st_q.pulsed   <= 1'b0;
            st_q.held_low <= 1'b0;
            st_q.pwm      <= PWM_HZ;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_state = st_q.pwm;

    // R10
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_state != 2'b11);

    // R9
    fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_fault || !en) |=> pwm_state == PWM_HZ);

    // R8
    ov_force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && ov_flag && st_q.mode != MD_IDLE) |=> pwm_state == PWM_LO);

    // R6
    min_on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_state == PWM_HI && st_q.on_cnt < MIN_ON_V && run_ok && !ov_flag
         && !cyc_tick && pos_nxt < HI_LIM_V) |=> pwm_state == PWM_HI);

    // R7
    max_on_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_state == PWM_HI |-> pos_q < HI_LIM_V);

    // R3
    nsync_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mode == MD_FCCM) |-> $past(st_q.ns_cnt) == NS_LAST_V);

endmodule

// File: tb/tb_pwm_tristate_seq.sv
`timescale 1ns/1ps
module tb_pwm_tristate_seq;

    localparam int PER      = 48;
    localparam int MIN_ON   = 4;
    localparam int HI_LIM   = PER - PER / 12;
    localparam int LOW_ST   = PER - 4;
    localparam int COMP_MIN = 10;
    localparam int NROWS    = 14;
    localparam int NSYNC    = 7;

    localparam logic [1:0] C_LO = 2'b00;
    localparam logic [1:0] C_HI = 2'b01;
    localparam logic [1:0] C_HZ = 2'b10;

    // {comp, ramp offset}; rows 0..6 fall in nonsynchronous periods, the rest in continuous ones
    localparam logic [15:0] ROWS [NROWS] = '{
        {8'd20, 8'd0}, {8'd10, 8'd0}, {8'd11, 8'd0}, {8'd60, 8'd0},
        {8'd20, 8'd30}, {8'd2, 8'd0}, {8'd33, 8'd10},
        {8'd20, 8'd0}, {8'd10, 8'd0}, {8'd11, 8'd0}, {8'd255, 8'd0},
        {8'd20, 8'd30}, {8'd30, 8'd25}, {8'd0, 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic [7:0] ramp = '0;
    logic [7:0] comp = '0;
    logic [7:0] ss_level = '0;
    logic       en = 1'b0;
    logic       prebias = 1'b0;
    logic       oc_fault = 1'b0;
    logic       ov_flag = 1'b0;
    logic [1:0] pwm_state;

    int total = 0;
    int bad = 0;
    bit saw_11 = 1'b0;
    bit done = 1'b0;
    logic [1:0] smp  [PER];
    logic [1:0] expv [PER];

    always #2.5 clk = ~clk;

    pwm_tristate_seq dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_tick  (cyc_tick),
        .ramp      (ramp),
        .comp      (comp),
        .ss_level  (ss_level),
        .en        (en),
        .prebias   (prebias),
        .oc_fault  (oc_fault),
        .ov_flag   (ov_flag),
        .pwm_state (pwm_state)
    );

    function automatic logic [1:0] exp_at(bit fccm, int c, int roff, int i);
        int h;
        int ioff;
        h = 0;
        if (c > COMP_MIN) begin
            ioff = c - roff + 1;
            if (ioff < 1) ioff = 1;
            h = (ioff < MIN_ON) ? MIN_ON : ioff;
            if (h > HI_LIM) h = HI_LIM;
        end
        if (i < h)                     return C_HI;
        else if (fccm)                 return C_LO;
        else if (h > 0 && i >= LOW_ST) return C_LO;
        else                           return C_HZ;
    endfunction

    task automatic fill_std(bit fccm, int c, int roff);
        for (int i = 0; i < PER; i++) expv[i] = exp_at(fccm, c, roff, i);
    endtask

    task automatic fill_all(logic [1:0] v);
        for (int i = 0; i < PER; i++) expv[i] = v;
    endtask

    // one switching period; flags are active for positions [from, to)
    task automatic run_period(int c, int roff, int ovf, int ovt, int ocf, int oct, int enf);
        for (int i = 0; i < PER; i++) begin
            @(negedge clk);
            cyc_tick = (i == 0);
            ramp     = (i + roff > 255) ? 8'd255 : 8'(i + roff);
            comp     = 8'(c);
            ov_flag  = (i >= ovf && i < ovt);
            oc_fault = (i >= ocf && i < oct);
            en       = (i < enf);
            @(posedge clk);
            #1;
            smp[i] = pwm_state;
            if (pwm_state == 2'b11) saw_11 = 1'b1;
        end
        @(negedge clk);
        cyc_tick = 1'b0;
        ov_flag  = 1'b0;
        oc_fault = 1'b0;
    endtask

    task automatic chk_period(string rq, string what);
        bit ok;
        ok = 1'b1;
        total++;
        for (int i = 0; i < PER; i++) begin
            if (ok && smp[i] !== expv[i]) begin
                ok = 1'b0;
                bad++;
                $display("FAIL %s %s pos=%0d actual=%b expected=%b", rq, what, i, smp[i], expv[i]);
            end
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        total++;
        if (pwm_state !== C_HZ) begin
            bad++;
            $display("FAIL R1 reset actual=%b expected=%b", pwm_state, C_HZ);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: disabled with a valid comp, no switching
        run_period(20, 0, -1, -1, -1, -1, 0);
        fill_all(C_HZ);
        chk_period("R1", "disabled");

        // R3 R4 R5 R6 R7: table, first start at row 0 (R2)
        for (int r = 0; r < NROWS; r++) begin
            int c;
            int ro;
            c  = int'(ROWS[r][15:8]);
            ro = int'(ROWS[r][7:0]);
            run_period(c, ro, -1, -1, -1, -1, PER);
            fill_std(r >= NSYNC, c, ro);
            chk_period(r >= NSYNC ? "R4" : "R3", $sformatf("row%0d", r));
        end

        // R8: overvoltage at positions 2..4, low held to period end
        run_period(40, 0, 2, 5, -1, -1, PER);
        fill_std(1'b1, 40, 0);
        for (int i = 2; i < PER; i++) expv[i] = C_LO;
        chk_period("R8", "ov_hold");
        run_period(40, 0, -1, -1, -1, -1, PER);
        fill_std(1'b1, 40, 0);
        chk_period("R8", "ov_recover");

        // R9: overcurrent at position 5 releases the pin
        run_period(40, 0, -1, -1, 5, 8, PER);
        fill_std(1'b1, 40, 0);
        for (int i = 5; i < PER; i++) expv[i] = C_HZ;
        chk_period("R9", "oc_release");

        // R2: prebias blocks start
        prebias = 1'b1;
        run_period(20, 0, -1, -1, -1, -1, PER);
        prebias = 1'b0;
        fill_all(C_HZ);
        chk_period("R2", "prebias_block");

        // R2: neither comp nor soft-start above threshold
        ss_level = 8'd5;
        run_period(5, 0, -1, -1, -1, -1, PER);
        fill_all(C_HZ);
        chk_period("R2", "no_level");

        // R2 R5: soft-start level alone starts; comp low keeps the period released
        ss_level = 8'd30;
        run_period(5, 0, -1, -1, -1, -1, PER);
        ss_level = 8'd0;
        fill_all(C_HZ);
        chk_period("R2", "ss_start");

        // R9 R3: restart reruns the nonsynchronous sequence (periods 2..7)
        for (int k = 0; k < NSYNC - 1; k++) begin
            run_period(20, 0, -1, -1, -1, -1, PER);
            fill_std(1'b0, 20, 0);
            chk_period("R9", $sformatf("rerun%0d", k));
        end
        run_period(20, 0, -1, -1, -1, -1, PER);
        fill_std(1'b1, 20, 0);
        chk_period("R4", "continuous_after_rerun");

        // R1: enable dropped at position 3
        run_period(20, 0, -1, -1, -1, -1, 3);
        fill_std(1'b1, 20, 0);
        for (int i = 3; i < PER; i++) expv[i] = C_HZ;
        chk_period("R1", "enable_drop");

        // R10: no illegal code seen at any sample
        total++;
        if (saw_11) begin
            bad++;
            $display("FAIL R10 code actual=11 expected=none");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule